// File: doc/BRIEF.md
# Decision-Diagram Evaluation Engine

The engine evaluates a Boolean function held as an ordered binary decision diagram in a small on-chip node table. Each stored node names one input variable and two child node IDs, one for the variable equal to 0 and one for it equal to 1. IDs 0 and 1 are never stored. They stand for the constant-0 and constant-1 terminals. A separate register holds the ID of the root node.

Software or a loader fills the table and the root register through a simple write port. A start strobe then captures an input vector. Starting at the root, the engine follows one edge per clock cycle, choosing the edge from the captured value of that node's variable, until it reaches a terminal. It then pulses `done` and presents the terminal's value on `result`.

The engine checks each node it visits. The variable index must fall inside the configured variable count. It must also be strictly lower than the index of the node visited just before it. The two children of a node must differ. If any check fails, the walk stops and raises `err` in place of a result.

Top module: `bdd_eval_engine`

## Requirements
- R1: After reset, `busy`, `done`, `result` and `err` are 0 and the root register holds ID 0, so a walk started before any programming returns 0.
- R2: Root ID 0 yields result 0 and root ID 1 yields result 1, each with `done` one cycle after the start edge; writes to table IDs 0 and 1 never change these constants.
- R3: At a stored node, an input bit of 0 selects the low child and 1 selects the high child, so `result` equals x'·f(low) + x·f(high) for every input vector.
- R4: One node is visited per cycle: a path through n stored nodes raises `done` n+1 cycles after the start edge. `busy` is high from the start edge until the edge that raises `done`, and `done` is a single-cycle pulse.
- R5: A visited node whose variable index is not strictly below the previous node's index ends the walk with `err`=1 and `result`=0.
- R6: A visited node whose low and high children are equal ends the walk with `err`=1 and `result`=0.
- R7: A visited node whose variable index is not below NUM_VARS ends the walk with `err`=1 and `result`=0.
- R8: Table writes and root writes presented while `busy` is high are discarded.
- R9: A start strobe while `busy` is high is ignored and not queued. `result` and `err` change only on the edge that raises `done` and hold until the next completion.
- R10: A table write presented on the same edge that accepts a start is stored and is seen by that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Node-table write enable |
| tbl_addr | input | ID_W | Node ID written |
| tbl_var | input | VAR_W | Variable index of the written node |
| tbl_lo | input | ID_W | Child ID for variable = 0 |
| tbl_hi | input | ID_W | Child ID for variable = 1 |
| root_we | input | 1 | Root register write enable |
| root_id | input | ID_W | New root node ID |
| start | input | 1 | Begin a walk with `in_vec` |
| in_vec | input | NUM_VARS | Input assignment, bit i is variable i |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 1 | Function value of the last walk |
| err | output | 1 | Last walk aborted on a malformed node |

## Verification
Two events can share one edge: a table write and the start of a walk. The bench presents both on the same edge. It replaces a node on the chosen path with inverted children and expects the inverted value, because the write lands as the walk begins and the node is read in a later cycle. A second pair also shares edges: a write or a second start that arrives while the walk advances. The bench presents these mid-walk and judges them by the walk's own result. Follow-up walks then show that the table, the root and the output registers were left untouched.

// File: rtl/bdd_pkg.sv
package bdd_pkg;
   typedef enum logic [0:0] {
      WALK_IDLE = 1'b0,
      WALK_RUN  = 1'b1
   } walk_state_e;

   // terminal IDs occupy the two lowest codes
   function automatic logic is_terminal(input logic [31:0] id);
      return id < 32'd2;
   endfunction
endpackage

// File: rtl/bdd_node_table.sv
module bdd_node_table #(
   parameter int ID_W  = 5,
   parameter int VAR_W = 3
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic             lock,
   input  logic [ID_W-1:0]  wr_addr,
   input  logic [VAR_W-1:0] wr_var,
   input  logic [ID_W-1:0]  wr_lo,
   input  logic [ID_W-1:0]  wr_hi,
   input  logic [ID_W-1:0]  rd_addr,
   output logic [VAR_W-1:0] rd_var,
   output logic [ID_W-1:0]  rd_lo,
   output logic [ID_W-1:0]  rd_hi
);
   localparam int DEPTH = 1 << ID_W;

   logic [VAR_W-1:0] var_mem [DEPTH];
   logic [ID_W-1:0]  lo_mem  [DEPTH];
   logic [ID_W-1:0]  hi_mem  [DEPTH];
   logic             wr_ok;

   assign wr_ok = wr_en && !lock && !bdd_pkg::is_terminal(32'(wr_addr));

   always_ff @(posedge clk) begin
      if (wr_ok) begin
         var_mem[wr_addr] <= wr_var;
         lo_mem[wr_addr]  <= wr_lo;
         hi_mem[wr_addr]  <= wr_hi;
      end
   end

   assign rd_var = var_mem[rd_addr];
   assign rd_lo  = lo_mem[rd_addr];
   assign rd_hi  = hi_mem[rd_addr];
endmodule

// File: rtl/bdd_node_check.sv
module bdd_node_check #(
   parameter int ID_W     = 5,
   parameter int VAR_W    = 3,
   parameter int NUM_VARS = 6,
   parameter bit STRICT   = 1'b1
) (
   input  logic [VAR_W-1:0] node_var,
   input  logic [ID_W-1:0]  node_lo,
   input  logic [ID_W-1:0]  node_hi,
   input  logic [VAR_W-1:0] prev_var,
   input  logic             have_parent,
   output logic             fault
);
   logic range_bad;
   assign range_bad = {1'b0, node_var} >= (VAR_W+1)'(NUM_VARS);

   generate
      if (STRICT) begin : g_strict
         logic order_bad, twin_bad;
         assign order_bad = have_parent && (node_var >= prev_var);
         assign twin_bad  = (node_lo == node_hi);
         assign fault     = range_bad || order_bad || twin_bad;
      end else begin : g_loose
         logic unused_ok;
         assign unused_ok = &{1'b0, node_lo, node_hi, prev_var, have_parent};
         assign fault     = range_bad;
      end
   endgenerate
endmodule

// File: rtl/bdd_walker.sv
module bdd_walker #(
   parameter int ID_W     = 5,
   parameter int VAR_W    = 3,
   parameter int NUM_VARS = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [NUM_VARS-1:0] in_vec,
   input  logic [ID_W-1:0]     root,
   input  logic [VAR_W-1:0]    node_var,
   input  logic [ID_W-1:0]     node_lo,
   input  logic [ID_W-1:0]     node_hi,
   input  logic                node_fault,
   output logic [ID_W-1:0]     cur_id,
   output logic [VAR_W-1:0]    prev_var,
   output logic                have_parent,
   output logic                busy,
   output logic                done,
   output logic                result,
   output logic                err
);
   import bdd_pkg::*;
   localparam int LAT_W = 1 << VAR_W;

   walk_state_e      state;
   logic [LAT_W-1:0] in_lat;
   logic             at_leaf;
   logic             take_hi;

   assign at_leaf = is_terminal(32'(cur_id));
   assign take_hi = in_lat[node_var];
   assign busy    = (state == WALK_RUN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= WALK_IDLE;
         cur_id      <= '0;
         prev_var    <= '0;
         have_parent <= 1'b0;
         in_lat      <= '0;
         done        <= 1'b0;
         result      <= 1'b0;
         err         <= 1'b0;
      end else begin
         done <= 1'b0;
         if (state == WALK_IDLE) begin
            if (start) begin
               state       <= WALK_RUN;
               cur_id      <= root;
               have_parent <= 1'b0;
               in_lat      <= LAT_W'(in_vec);
            end
         end else if (at_leaf) begin
            state  <= WALK_IDLE;
            done   <= 1'b1;
            result <= cur_id[0];
            err    <= 1'b0;
         end else if (node_fault) begin
            state  <= WALK_IDLE;
            done   <= 1'b1;
            result <= 1'b0;
            err    <= 1'b1;
         end else begin
            cur_id      <= take_hi ? node_hi : node_lo;
            prev_var    <= node_var;
            have_parent <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/bdd_eval_engine.sv
module bdd_eval_engine #(
   parameter int NUM_VARS = 6,
   parameter int ID_W     = 5,
   parameter bit STRICT   = 1'b1,
   localparam int VAR_W   = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tbl_we,
   input  logic [ID_W-1:0]     tbl_addr,
   input  logic [VAR_W-1:0]    tbl_var,
   input  logic [ID_W-1:0]     tbl_lo,
   input  logic [ID_W-1:0]     tbl_hi,
   input  logic                root_we,
   input  logic [ID_W-1:0]     root_id,
   input  logic                start,
   input  logic [NUM_VARS-1:0] in_vec,
   output logic                busy,
   output logic                done,
   output logic                result,
   output logic                err
);
   generate
      if (NUM_VARS < 2) begin : g_bad_vars
         $error("NUM_VARS must be at least 2");
      end
      if (ID_W < 2 || ID_W > 10) begin : g_bad_id
         $error("ID_W must lie in 2..10");
      end
   endgenerate

   logic [ID_W-1:0]  root_q;
   logic [ID_W-1:0]  cur_id;
   logic [VAR_W-1:0] node_var, prev_var;
   logic [ID_W-1:0]  node_lo, node_hi;
   logic             have_parent, node_fault;

   always_ff @(posedge clk) begin
      if (!rst_n)                root_q <= '0;
      else if (root_we && !busy) root_q <= root_id;
   end

   bdd_node_table #(.ID_W(ID_W), .VAR_W(VAR_W)) table_i (
      .clk(clk), .wr_en(tbl_we), .lock(busy), .wr_addr(tbl_addr),
      .wr_var(tbl_var), .wr_lo(tbl_lo), .wr_hi(tbl_hi), .rd_addr(cur_id),
      .rd_var(node_var), .rd_lo(node_lo), .rd_hi(node_hi)
   );

   bdd_node_check #(.ID_W(ID_W), .VAR_W(VAR_W), .NUM_VARS(NUM_VARS),
                    .STRICT(STRICT)) check_i (
      .node_var(node_var), .node_lo(node_lo), .node_hi(node_hi),
      .prev_var(prev_var), .have_parent(have_parent), .fault(node_fault)
   );

   bdd_walker #(.ID_W(ID_W), .VAR_W(VAR_W), .NUM_VARS(NUM_VARS)) walk_i (
      .clk(clk), .rst_n(rst_n), .start(start), .in_vec(in_vec), .root(root_q),
      .node_var(node_var), .node_lo(node_lo), .node_hi(node_hi),
      .node_fault(node_fault), .cur_id(cur_id), .prev_var(prev_var),
      .have_parent(have_parent), .busy(busy), .done(done), .result(result),
      .err(err)
   );
endmodule

// File: rtl/bdd_eval_engine_chk.sv
module bdd_eval_engine_chk #(
   parameter int NUM_VARS = 6
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic result,
   input logic err
);
   logic [15:0] walk_len;

   always_ff @(posedge clk) begin
      if (!rst_n)    walk_len <= '0;
      else if (busy) walk_len <= walk_len + 16'd1;
      else           walk_len <= '0;
   end

   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_ends_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   p_walk_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (walk_len <= 16'(NUM_VARS)));
   p_err_forces_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !result);
   p_busy_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   p_result_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);
   p_err_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(err) |-> done);
endmodule

bind bdd_eval_engine bdd_eval_engine_chk #(.NUM_VARS(NUM_VARS)) chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .result(result), .err(err)
);

// File: tb/bdd_eval_engine_tb_top.sv
`timescale 1ns/1ps
module bdd_eval_engine_tb_top;
   localparam int NV = 6;
   localparam int IW = 5;
   localparam int VW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tbl_we = 1'b0;
   logic [IW-1:0] tbl_addr = '0;
   logic [VW-1:0] tbl_var = '0;
   logic [IW-1:0] tbl_lo = '0, tbl_hi = '0;
   logic          root_we = 1'b0;
   logic [IW-1:0] root_id = '0;
   logic          start = 1'b0;
   logic [NV-1:0] in_vec = '0;
   logic          busy, done, result, err;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   bdd_eval_engine #(.NUM_VARS(NV), .ID_W(IW)) dut_i (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_var(tbl_var), .tbl_lo(tbl_lo), .tbl_hi(tbl_hi), .root_we(root_we),
      .root_id(root_id), .start(start), .in_vec(in_vec), .busy(busy),
      .done(done), .result(result), .err(err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reference function of the programmed diagram
   function automatic bit ref_f(input logic [NV-1:0] x);
      if (!x[5]) return x[3] ? !x[0] : 1'b0;
      return x[2] ? 1'b1 : !x[0];
   endfunction

   function automatic int ref_len(input logic [NV-1:0] x);
      if (!x[5]) return x[3] ? 4 : 3;
      return x[2] ? 3 : 4;
   endfunction

   task automatic wr_node(input int id, input int v, input int lo, input int hi);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = IW'(id); tbl_var = VW'(v);
      tbl_lo = IW'(lo); tbl_hi = IW'(hi);
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic set_root(input int id);
      @(negedge clk);
      root_we = 1'b1; root_id = IW'(id);
      @(negedge clk);
      root_we = 1'b0;
   endtask

   // waits for done after an accepted start; called at the negedge after the accept edge
   task automatic wait_done(output int cyc);
      cyc = 0;
      while (!done && cyc < 100) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic run_eval(input logic [NV-1:0] x, output bit res, output bit e,
                           output int cyc);
      @(negedge clk);
      start = 1'b1; in_vec = x;
      @(negedge clk);
      start = 1'b0;
      wait_done(cyc);
      res = result; e = err;
   endtask

   task automatic load_diagram();
      wr_node(2, 5, 3, 4);
      wr_node(3, 3, 0, 5);
      wr_node(4, 2, 5, 1);
      wr_node(5, 0, 1, 0);
      set_root(2);
   endtask

   task automatic t_reset();
      bit r, e; int c;
      check(busy == 1'b0 && done == 1'b0, "R1 busy/done after reset", int'({busy, done}), 0);
      check(result == 1'b0 && err == 1'b0, "R1 result/err after reset", int'({result, err}), 0);
      run_eval('1, r, e, c);
      check(r == 1'b0 && e == 1'b0, "R1 default root evaluates to 0", int'({r, e}), 0);
      check(c == 1, "R2 leaf root completes in 1 cycle", c, 1);
   endtask

   task automatic t_leaf();
      bit r, e; int c;
      wr_node(1, 0, 2, 3);
      wr_node(0, 0, 2, 3);
      set_root(1);
      run_eval('0, r, e, c);
      check(r == 1'b1 && e == 1'b0, "R2 root ID 1 gives constant 1", int'(r), 1);
      check(c == 1, "R2 constant-1 latency", c, 1);
      set_root(0);
      run_eval('1, r, e, c);
      check(r == 1'b0 && c == 1, "R2 root ID 0 gives constant 0", int'(r), 0);
   endtask

   task automatic t_func();
      bit r, e; int c; int bad = 0;
      load_diagram();
      for (int v = 0; v < 64; v++) begin
         run_eval(NV'(v), r, e, c);
         if (r != ref_f(NV'(v)) || e) begin
            bad++;
            $display("FAIL R3 vector %0d actual=%0d expected=%0d", v, r, ref_f(NV'(v)));
         end
         if (c != ref_len(NV'(v))) begin
            bad++;
            $display("FAIL R4 vector %0d cycles actual=%0d expected=%0d", v, c, ref_len(NV'(v)));
         end
      end
      n_checks++;
      if (bad != 0) n_fail++;
      run_eval(6'b001000, r, e, c);
      check(r == 1'b1 && c == 4, "R4 three-node path", c, 4);
      run_eval(6'b000000, r, e, c);
      check(r == 1'b0 && c == 3, "R4 two-node path", c, 3);
   endtask

   task automatic t_faults();
      bit r, e; int c;
      wr_node(6, 1, 7, 1);
      wr_node(7, 3, 0, 1);
      set_root(6);
      run_eval('0, r, e, c);
      check(e == 1'b1 && r == 1'b0, "R5 order violation flags err", int'({e, r}), 2);
      wr_node(8, 2, 1, 1);
      set_root(8);
      run_eval('0, r, e, c);
      check(e == 1'b1 && r == 1'b0, "R6 equal children flags err", int'({e, r}), 2);
      wr_node(9, 7, 0, 1);
      set_root(9);
      run_eval('1, r, e, c);
      check(e == 1'b1 && r == 1'b0, "R7 index out of range flags err", int'({e, r}), 2);
      set_root(2);
      run_eval(6'b100100, r, e, c);
      check(e == 1'b0 && r == 1'b1, "R5 err clears on good walk", int'({e, r}), 1);
   endtask

   task automatic t_busy_write();
      bit r, e; int c;
      @(negedge clk);
      start = 1'b1; in_vec = 6'b001000;
      @(negedge clk);
      start = 1'b0;
      tbl_we = 1'b1; tbl_addr = 5; tbl_var = 0; tbl_lo = 0; tbl_hi = 1;
      root_we = 1'b1; root_id = 1;
      @(negedge clk);
      tbl_we = 1'b0; root_we = 1'b0;
      wait_done(c);
      check(result == 1'b1, "R8 walk unaffected by busy write", int'(result), 1);
      run_eval(6'b001000, r, e, c);
      check(r == 1'b1, "R8 table write while busy discarded", int'(r), 1);
      run_eval(6'b000000, r, e, c);
      check(r == 1'b0, "R8 root write while busy discarded", int'(r), 0);
   endtask

   task automatic t_start_busy();
      int c; int extra = 0;
      @(negedge clk);
      start = 1'b1; in_vec = 6'b000000;
      @(negedge clk);
      in_vec = 6'b100100;
      @(negedge clk);
      start = 1'b0;
      wait_done(c);
      check(result == 1'b0, "R9 second start ignored", int'(result), 0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (done || busy || result) extra++;
      end
      check(extra == 0, "R9 no queued walk and result held", extra, 0);
   endtask

   task automatic t_same_edge();
      bit r, e; int c;
      @(negedge clk);
      start = 1'b1; in_vec = 6'b001000;
      tbl_we = 1'b1; tbl_addr = 5; tbl_var = 0; tbl_lo = 0; tbl_hi = 1;
      @(negedge clk);
      start = 1'b0; tbl_we = 1'b0;
      wait_done(c);
      check(result == 1'b0, "R10 write on start edge seen by walk", int'(result), 0);
      wr_node(5, 0, 1, 0);
      run_eval(6'b001000, r, e, c);
      check(r == 1'b1, "R10 restored node", int'(r), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_leaf();
      t_func();
      t_faults();
      t_busy_write();
      t_start_busy();
      t_same_edge();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule